// File: doc/BRIEF.md
# Power-Up Battery Probe Sequencer

This block runs a short test on a battery-backed byte memory to learn whether the backup battery held its charge while main power was off. The memory is assumed to reject its first write after a power-up on a weak battery. The sequencer reads one byte from a fixed probe address. It writes the inverted byte back to that address and reads the address again. If the second read returns the inverted value, the write took effect and the battery is healthy, so the sequencer puts the original byte back. If the second read does not return the inverted value, the write was rejected. The sequencer then reports a low battery and flags that stored contents may be damaged.

The sequence starts by itself once reset is released, and it can be run again with a start pulse after it finishes. The block drives a plain synchronous memory port with a read strobe, a write strobe, an address and write data. Read data returns a fixed number of cycles after the read strobe, and that number is a parameter. Every output comes from a register.

Top module: `bat_probe`

## Requirements
- R1: While rst is high at a clock edge, that edge clears done, battery_low, data_suspect, mem_we and mem_re to 0.
- R2: After reset is released, the sequence starts without any start pulse. The first memory access is a read (mem_re high for one cycle) at address TEST_ADDR.
- R3: The second access is a one-cycle write to TEST_ADDR. Its data is the bitwise inverse of the byte returned by the first read.
- R4: The third access is a read of TEST_ADDR. mem_we and mem_re are never high together, and each strobe lasts exactly one cycle.
- R5: Read data is taken from mem_rdata only in the cycle that begins RD_LAT clock edges after the edge that samples mem_re high. mem_rdata at any other time has no effect.
- R6: If the second read returns the inverse of the first, a fourth access writes the original byte back to TEST_ADDR. The run then ends with battery_low = 0 and data_suspect = 0.
- R7: If the second read differs from the inverse of the first, no fourth access is made. The run ends with battery_low = 1 and data_suspect = 1.
- R8: Count as edge 1 either the first edge at which rst is sampled low or the edge that samples start high in the finished state. done is then high after edge 2*RD_LAT+6. done stays high, and no memory access occurs, until the next start.
- R9: A start pulse while done is high runs a fresh sequence: done and both flags drop after edge 1, and the result is judged again. A start pulse while a run is in progress is ignored, and the access trace and timing stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; its release starts a run |
| start | input | 1 | Pulse to run the test again after done |
| mem_addr | output | AW | Memory address (always TEST_ADDR) |
| mem_wdata | output | DW | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | DW | Memory read data, valid RD_LAT cycles after the read strobe |
| done | output | 1 | Test finished; flags valid while high |
| battery_low | output | 1 | Inverted write did not stick |
| data_suspect | output | 1 | Stored contents may be damaged |

## Verification
The bench builds the block with an 8-bit data path, an 11-bit address, a probe address of 0x3A5 and a read latency of 2. A latency above one exercises the multi-stage valid pipeline. The bench memory drives altered data in every cycle outside the valid window, so a capture that is off by one cycle shows up as wrong write data. The bench memory can be armed to drop its next write, which reaches the low-battery path. Probe bytes 0x00, 0xFF and mixed patterns check the inversion and the restore across all bit positions.

// File: rtl/bat_probe_pkg.sv
package bat_probe_pkg;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_FETCH   = 3'd1,
    S_INVERT  = 3'd2,
    S_REFETCH = 3'd3,
    S_JUDGE   = 3'd4,
    S_RESTORE = 3'd5,
    S_FLAG    = 3'd6,
    S_DONE    = 3'd7
  } probe_state_t;

endpackage

// File: rtl/bat_probe_rdpipe.sv
// Tracks the fixed read latency of the memory port: rvalid is high in the
// cycle in which read data for a strobe issued RD_LAT edges earlier is valid.
module bat_probe_rdpipe #(
  parameter int RD_LAT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  output logic rvalid
);

  logic [RD_LAT-1:0] stage_q;

  generate
    if (RD_LAT == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= issue;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= {stage_q[RD_LAT-2:0], issue};
      end
    end
  endgenerate

  assign rvalid = stage_q[RD_LAT-1];

endmodule

// File: rtl/bat_probe_capture.sv
// Holds the first and second read values and judges whether the inverted
// write took effect.
module bat_probe_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_first,
  input  logic          cap_second,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] orig,
  output logic          match
);

  logic [DW-1:0] orig_q;
  logic [DW-1:0] again_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      orig_q  <= '0;
      again_q <= '0;
    end else begin
      if (cap_first)  orig_q  <= rdata;
      if (cap_second) again_q <= rdata;
    end
  end

  assign orig  = orig_q;
  assign match = (again_q == ~orig_q);

  a_r4_capture_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(cap_first && cap_second));

endmodule

// File: rtl/bat_probe_fsm.sv
module bat_probe_fsm
  import bat_probe_pkg::*;
#(
  parameter int            DW        = 8,
  parameter int            AW        = 11,
  parameter logic [AW-1:0] TEST_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          rvalid,
  input  logic          match,
  input  logic [DW-1:0] rdata,
  input  logic [DW-1:0] orig,
  output logic          cap_first,
  output logic          cap_second,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic          done,
  output logic          battery_low,
  output logic          data_suspect
);

  probe_state_t state_q;

  assign cap_first  = (state_q == S_FETCH)   && rvalid;
  assign cap_second = (state_q == S_REFETCH) && rvalid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      mem_addr     <= TEST_ADDR;
      mem_wdata    <= '0;
      mem_we       <= 1'b0;
      mem_re       <= 1'b0;
      done         <= 1'b0;
      battery_low  <= 1'b0;
      data_suspect <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          state_q <= S_FETCH;
          mem_re  <= 1'b1;
        end
        S_FETCH: begin
          if (rvalid) begin
            state_q   <= S_INVERT;
            mem_we    <= 1'b1;
            mem_wdata <= ~rdata;
          end
        end
        S_INVERT: begin
          state_q <= S_REFETCH;
          mem_re  <= 1'b1;
        end
        S_REFETCH: begin
          if (rvalid) state_q <= S_JUDGE;
        end
        S_JUDGE: begin
          if (match) begin
            state_q   <= S_RESTORE;
            mem_we    <= 1'b1;
            mem_wdata <= orig;
          end else begin
            state_q <= S_FLAG;
          end
        end
        S_RESTORE: begin
          state_q      <= S_DONE;
          done         <= 1'b1;
          battery_low  <= 1'b0;
          data_suspect <= 1'b0;
        end
        S_FLAG: begin
          state_q      <= S_DONE;
          done         <= 1'b1;
          battery_low  <= 1'b1;
          data_suspect <= 1'b1;
        end
        S_DONE: begin
          if (start) begin
            state_q      <= S_FETCH;
            mem_re       <= 1'b1;
            done         <= 1'b0;
            battery_low  <= 1'b0;
            data_suspect <= 1'b0;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R4: strobes are exclusive single-cycle pulses
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));
  a_r4_re_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> !mem_re);
  a_r4_we_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R3: the first write carries the inverse of the captured byte
  a_r3_comp_data: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_INVERT) |-> (mem_wdata == ~orig));

  // R5: read data only arrives while a read is awaited
  a_r5_valid_when_waiting: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> (state_q == S_FETCH || state_q == S_REFETCH));

  // R6: restore write carries the original byte and precedes a good result
  a_r6_restore_data: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_RESTORE) |-> (mem_we && mem_wdata == orig));
  a_r6_restore_seen: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) && !battery_low) |-> $past(mem_we));

  // R7: a low result comes without a restore, and both flags agree
  a_r7_no_restore_on_low: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) && battery_low) |-> !$past(mem_we));
  a_r7_flags_agree: assert property (@(posedge clk) disable iff (rst)
    done |-> (data_suspect == battery_low));

  // R8: the port is quiet while the result is held
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> (!mem_we && !mem_re));

endmodule

// File: rtl/bat_probe.sv
module bat_probe #(
  parameter int            DW        = 8,
  parameter int            AW        = 11,
  parameter int            RD_LAT    = 1,
  parameter logic [AW-1:0] TEST_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          battery_low,
  output logic          data_suspect
);

  logic          rvalid;
  logic          match;
  logic          cap_first;
  logic          cap_second;
  logic [DW-1:0] orig;

  bat_probe_rdpipe #(.RD_LAT(RD_LAT)) u_rdpipe (
    .clk    (clk),
    .rst    (rst),
    .issue  (mem_re),
    .rvalid (rvalid)
  );

  bat_probe_capture #(.DW(DW)) u_capture (
    .clk        (clk),
    .rst        (rst),
    .cap_first  (cap_first),
    .cap_second (cap_second),
    .rdata      (mem_rdata),
    .orig       (orig),
    .match      (match)
  );

  bat_probe_fsm #(.DW(DW), .AW(AW), .TEST_ADDR(TEST_ADDR)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .rvalid       (rvalid),
    .match        (match),
    .rdata        (mem_rdata),
    .orig         (orig),
    .cap_first    (cap_first),
    .cap_second   (cap_second),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_we       (mem_we),
    .mem_re       (mem_re),
    .done         (done),
    .battery_low  (battery_low),
    .data_suspect (data_suspect)
  );

endmodule

// File: tb/bat_probe_bench.sv
module bat_probe_bench;
  localparam int            DW  = 8;
  localparam int            AW  = 11;
  localparam int            LAT = 2;
  localparam logic [AW-1:0] TA  = 11'h3A5;
  localparam int            RUN = 2*LAT + 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic mem_we, mem_re, done, battery_low, data_suspect;

  bat_probe #(.DW(DW), .AW(AW), .RD_LAT(LAT), .TEST_ADDR(TA)) u_bat_probe (
    .clk(clk), .rst(rst), .start(start),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .done(done), .battery_low(battery_low),
    .data_suspect(data_suspect)
  );

  // memory model with fixed latency and an armable write drop
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic          load_en = 1'b0;
  logic [DW-1:0] load_val = '0;
  logic          blk_arm = 1'b0;
  int            arm_id = 0;
  int            used_id = 0;
  logic [LAT-1:0] pv = '0;
  logic [DW-1:0]  pd0 = '0, pd1 = '0;
  logic           lg_w [0:255];
  logic [AW-1:0]  lg_a [0:255];
  logic [DW-1:0]  lg_d [0:255];
  int             log_n = 0;

  always @(posedge clk) begin
    if (load_en) mem[TA] <= load_val;
    if (mem_we) begin
      if (blk_arm && used_id != arm_id) used_id <= arm_id;
      else mem[mem_addr] <= mem_wdata;
    end
    pv  <= {pv[LAT-2:0], mem_re};
    pd0 <= mem[mem_addr];
    pd1 <= pd0;
    if (!rst && (mem_we || mem_re) && log_n < 256) begin
      lg_w[log_n] <= mem_we;
      lg_a[log_n] <= mem_addr;
      lg_d[log_n] <= mem_wdata;
      log_n <= log_n + 1;
    end
  end
  // outside the valid window the model drives altered data (R5)
  assign mem_rdata = pv[LAT-1] ? pd1 : pd1 + 8'h37;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad + 1);
      $finish;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic run(input bit via_rst, input logic [DW-1:0] v, input bit low,
                     input bit mid_start);
    int base;
    int cnt;
    logic bl;
    @(negedge clk);
    load_en = 1'b1; load_val = v; blk_arm = low; arm_id++;
    @(negedge clk);
    load_en = 1'b0;
    base = log_n;
    if (via_rst) begin
      rst = 1'b1;
      @(negedge clk);
      chk("R1 done", done, 0);
      chk("R1 strobes", {mem_we, mem_re}, 0);
      chk("R1 flags", {battery_low, data_suspect}, 0);
      @(negedge clk);
      rst = 1'b0;
    end else begin
      start = 1'b1;
    end
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      start = 1'b0;
      if (cnt == 1 && !via_rst) begin
        chk("R9 done drops", done, 0);
        chk("R9 flags drop", {battery_low, data_suspect}, 0);
      end
      if (mid_start && cnt == 4) start = 1'b1;
    end while (!done && cnt < 100);
    chk("R8 run length", cnt, RUN);
    chk("R2 first access read", {lg_w[base], lg_a[base]}, {1'b0, TA});
    chk("R3 R5 inverse write", {lg_w[base+1], lg_a[base+1], lg_d[base+1]}, {1'b1, TA, ~v});
    chk("R4 reread", {lg_w[base+2], lg_a[base+2]}, {1'b0, TA});
    if (!low) begin
      chk("R6 access count", log_n - base, 4);
      chk("R6 restore write", {lg_w[base+3], lg_a[base+3], lg_d[base+3]}, {1'b1, TA, v});
      chk("R6 flags", {battery_low, data_suspect}, 2'b00);
    end else begin
      chk("R7 access count", log_n - base, 3);
      chk("R7 flags", {battery_low, data_suspect}, 2'b11);
    end
    chk("R6 R7 byte kept", mem[TA], v);
    bl = battery_low;
    repeat (8) @(negedge clk);
    chk("R8 done held", done, 1);
    chk("R8 port quiet", log_n - base, low ? 3 : 4);
    chk("R8 flag held", battery_low, bl);
  endtask

  task automatic t_power_up_good();    run(1, 8'hA5, 0, 0); endtask
  task automatic t_power_up_low();     run(1, 8'h00, 1, 0); endtask
  task automatic t_rerun_good();       run(0, 8'hFF, 0, 0); endtask
  task automatic t_rerun_low();        run(0, 8'h5A, 1, 0); endtask
  task automatic t_rerun_after_low();  run(0, 8'h3C, 0, 0); endtask
  task automatic t_start_while_busy(); run(0, 8'h81, 0, 1); endtask
  task automatic t_busy_start_low();   run(0, 8'h7E, 1, 1); endtask

  initial begin
    t_power_up_good();
    t_power_up_low();
    t_rerun_good();
    t_rerun_low();
    t_rerun_after_low();
    t_start_while_busy();
    t_busy_start_low();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule